// File: doc/BRIEF.md
# SPI Engine Interrupt Controller

This block gathers the event pulses of a multi-channel SPI engine into one sticky status register. Each channel owns an 8-bit lane of that register and reports five events in it. Software reads the sticky status and clears bits by writing ones to them. A mask register picks which events may raise the single level interrupt line. A third view returns the status ANDed with the mask, and that view drives the interrupt.

The register port is a simple synchronous write strobe with a combinational read. It decodes three word offsets: 0x08 for the sticky status, 0x0C for the masked view and 0x10 for the mask. The number of channels is a parameter, and every lane follows the same layout. The asynchronous reset is released synchronously through a two-stage synchronizer, so the block accepts register traffic on the third rising edge after reset is released.

Top module: `spi_irq_ctrl`

## Requirements
- R1: After reset the status and the mask read 0, the masked view reads 0 and `irq_o` is low. An event that arrives while the mask is still zero sets its status bit but leaves `irq_o` low.
- R2: Event input `evt_i[5*c+k]` sets status bit `8*c+k` on the next rising edge. In each lane, k=0 is command complete, k=1 is receive overrun, k=2 is transmit underrun, k=3 is poll expiry and k=4 is bad control word. A set bit stays set while no clear reaches it.
- R3: A write to offset 0x08 clears each status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R4: When an event and a clear of the same bit land in the same cycle, the bit ends up set.
- R5: Bits 5 to 7 of every lane, and all bits above the last lane, read as 0 at all three offsets, even after ones are written to them.
- R6: Offset 0x0C reads the status ANDed with the mask.
- R7: `irq_o` is high exactly when the masked view is non-zero, and it follows status and mask changes in the same cycle they become visible.
- R8: Writing 0xFF001F1F to offset 0x08 clears every event of a two-channel configuration.
- R9: Writes to offset 0x0C or to any unmapped offset change neither the status nor the mask. Reads from unmapped offsets return 0.
- R10: A write to offset 0x10 loads the mask with the defined event bits of the data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_CH*5 | Single-cycle event pulses, five per channel |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Byte offset of the register access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| irq_o | output | 1 | Level interrupt, high while the masked view is non-zero |

## Verification
The bench builds the block with two channels, which is the default. With two channels the full-clear pattern 0xFF001F1F covers every defined bit, so that pattern can be checked for completeness and not just for partial effect. Two lanes also make it possible to check that a mask bit in one lane blocks or passes events of the other lane, and that the unused bits between and above the lanes stay zero.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

  localparam int LANE_W       = 8;
  localparam int EVT_PER_LANE = 5;
  localparam int REG_W        = 32;
  localparam int ADDR_W       = 5;

  localparam logic [ADDR_W-1:0] OFF_RAW   = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_MSTAT = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_MASK  = 5'h10;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_RAW   = 2'd1,
    SEL_MSTAT = 2'd2,
    SEL_MASK  = 2'd3
  } reg_sel_e;

  // Bits that carry a defined event for a given channel count
  function automatic logic [REG_W-1:0] defined_bits(input int nch);
    logic [REG_W-1:0] v;
    v = '0;
    for (int c = 0; c < nch; c++) begin
      for (int k = 0; k < EVT_PER_LANE; k++) begin
        v[c*LANE_W + k] = 1'b1;
      end
    end
    return v;
  endfunction

endpackage

// File: rtl/spi_irq_rst_sync.sv
module spi_irq_rst_sync (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/spi_irq_decode.sv
module spi_irq_decode
  import spi_irq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);

  always_comb begin
    unique case (addr_i)
      OFF_RAW:   sel_o = SEL_RAW;
      OFF_MSTAT: sel_o = SEL_MSTAT;
      OFF_MASK:  sel_o = SEL_MASK;
      default:   sel_o = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/spi_irq_lane.sv
module spi_irq_lane #(
  parameter int EVT_N = 5
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic [EVT_N-1:0] evt_i,
  input  logic             clr_en_i,
  input  logic [EVT_N-1:0] clr_bits_i,
  output logic [EVT_N-1:0] stat_o
);

  logic [EVT_N-1:0] stat_q;
  logic [EVT_N-1:0] stat_d;
  logic [EVT_N-1:0] clr_vec;

  assign clr_vec = clr_en_i ? clr_bits_i : '0;

  // Set has priority over clear
  always_comb begin
    stat_d = (stat_q & ~clr_vec) | evt_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      stat_q <= '0;
    end else begin
      stat_q <= stat_d;
    end
  end

  assign stat_o = stat_q;

  // R2
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    1'b1 |=> ((stat_q & $past(stat_q & ~clr_vec)) == $past(stat_q & ~clr_vec)));

  // R4
  event_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    1'b1 |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

  // R3
  w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    1'b1 |=> ((stat_q & $past(clr_vec & ~evt_i)) == '0));

endmodule

// File: rtl/spi_irq_mask.sv
module spi_irq_mask #(
  parameter int              W    = 32,
  parameter logic [W-1:0]    KEEP = '1
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);

  logic [W-1:0] mask_q;
  logic [W-1:0] mask_d;

  always_comb begin
    mask_d = mask_q;
    if (we_i) begin
      mask_d = wdata_i & KEEP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      mask_q <= '0;
    end else if (we_i) begin
      mask_q <= mask_d;
    end
  end

  assign mask_o = mask_q;

  // R10
  mask_load_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    we_i |=> (mask_q == ($past(wdata_i) & KEEP)));

endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_irq_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_n_i,
  input  logic [NUM_CH*EVT_PER_LANE-1:0] evt_i,
  input  logic                           reg_wr_i,
  input  logic [ADDR_W-1:0]              reg_addr_i,
  input  logic [REG_W-1:0]               reg_wdata_i,
  output logic [REG_W-1:0]               reg_rdata_o,
  output logic                           irq_o
);

  localparam int               USED_W  = NUM_CH * LANE_W;
  localparam int               PAD_W   = LANE_W - EVT_PER_LANE;
  localparam logic [REG_W-1:0] DEF_MSK = defined_bits(NUM_CH);

  logic                    rst_sync_n;
  reg_sel_e                sel;
  logic                    wr_raw;
  logic                    wr_mask;
  logic [REG_W-1:0]        raw_all;
  logic [REG_W-1:0]        mask_all;
  logic [REG_W-1:0]        mstat;
  logic [EVT_PER_LANE-1:0] lane_stat [NUM_CH];

  spi_irq_rst_sync u_rst_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_sync_n)
  );

  spi_irq_decode u_decode (
    .addr_i (reg_addr_i),
    .sel_o  (sel)
  );

  assign wr_raw  = reg_wr_i && (sel == SEL_RAW);
  assign wr_mask = reg_wr_i && (sel == SEL_MASK);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    spi_irq_lane #(.EVT_N(EVT_PER_LANE)) u_lane (
      .clk_i      (clk_i),
      .rst_n_i    (rst_sync_n),
      .evt_i      (evt_i[ch*EVT_PER_LANE +: EVT_PER_LANE]),
      .clr_en_i   (wr_raw),
      .clr_bits_i (reg_wdata_i[ch*LANE_W +: EVT_PER_LANE]),
      .stat_o     (lane_stat[ch])
    );
    assign raw_all[ch*LANE_W +: LANE_W] = {{PAD_W{1'b0}}, lane_stat[ch]};
  end

  if (USED_W < REG_W) begin : g_pad
    assign raw_all[REG_W-1:USED_W] = '0;
  end

  spi_irq_mask #(.W(REG_W), .KEEP(DEF_MSK)) u_mask (
    .clk_i   (clk_i),
    .rst_n_i (rst_sync_n),
    .we_i    (wr_mask),
    .wdata_i (reg_wdata_i),
    .mask_o  (mask_all)
  );

  assign mstat = raw_all & mask_all;
  assign irq_o = |mstat;

  always_comb begin
    unique case (sel)
      SEL_RAW:   reg_rdata_o = raw_all;
      SEL_MSTAT: reg_rdata_o = mstat;
      SEL_MASK:  reg_rdata_o = mask_all;
      default:   reg_rdata_o = '0;
    endcase
  end

  // R5
  undef_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    ((raw_all | mask_all) & ~DEF_MSK) == '0);

  // R7
  irq_level_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    irq_o == ((lane_stat[0] & mask_all[EVT_PER_LANE-1:0]) != '0 ||
              ((raw_all & mask_all & ~{{(REG_W-EVT_PER_LANE){1'b0}}, {EVT_PER_LANE{1'b1}}}) != '0)));

  // R9
  ro_write_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (reg_wr_i && sel != SEL_MASK) |=> $stable(mask_all));

endmodule

// File: tb/tb_spi_irq_ctrl.sv
`timescale 1ns/100ps
module tb_spi_irq_ctrl;
  import spi_irq_pkg::*;

  localparam int NCH  = 2;
  localparam int EVW  = NCH * EVT_PER_LANE;
  localparam int NVEC = 15;

  typedef struct packed {
    logic [EVW-1:0]    evt;
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [REG_W-1:0]  wdata;
    logic [REG_W-1:0]  exp_raw;
    logic [REG_W-1:0]  exp_mask;
    logic              exp_irq;
  } vec_t;

  // evt bit 5*c+k maps to status bit 8*c+k
  localparam vec_t VECS [NVEC] = '{
    '{10'h000, 1'b1, OFF_MASK,  32'h0000_0001, 32'h0000_0000, 32'h0000_0001, 1'b0}, // R10
    '{10'h001, 1'b0, OFF_RAW,   32'h0,         32'h0000_0001, 32'h0000_0001, 1'b1}, // R2 R7
    '{10'h040, 1'b0, OFF_RAW,   32'h0,         32'h0000_0201, 32'h0000_0001, 1'b1}, // R2
    '{10'h000, 1'b1, OFF_RAW,   32'h0000_0000, 32'h0000_0201, 32'h0000_0001, 1'b1}, // R3
    '{10'h000, 1'b1, OFF_RAW,   32'h0000_0001, 32'h0000_0200, 32'h0000_0001, 1'b0}, // R3 R7
    '{10'h000, 1'b1, OFF_MASK,  32'h0000_0200, 32'h0000_0200, 32'h0000_0200, 1'b1}, // R10
    '{10'h010, 1'b1, OFF_RAW,   32'h0000_0010, 32'h0000_0210, 32'h0000_0200, 1'b1}, // R4
    '{10'h180, 1'b0, OFF_RAW,   32'h0,         32'h0000_0E10, 32'h0000_0200, 1'b1}, // R2
    '{10'h3FF, 1'b0, OFF_RAW,   32'h0,         32'h0000_1F1F, 32'h0000_0200, 1'b1}, // R5
    '{10'h000, 1'b1, OFF_MSTAT, 32'hFFFF_FFFF, 32'h0000_1F1F, 32'h0000_0200, 1'b1}, // R9
    '{10'h000, 1'b1, OFF_RAW,   32'hFF00_1F1F, 32'h0000_0000, 32'h0000_0200, 1'b0}, // R8
    '{10'h000, 1'b1, OFF_MASK,  32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_1F1F, 1'b0}, // R5
    '{10'h004, 1'b0, OFF_RAW,   32'h0,         32'h0000_0004, 32'h0000_1F1F, 1'b1}, // R2
    '{10'h000, 1'b1, 5'h00,     32'hFFFF_FFFF, 32'h0000_0004, 32'h0000_1F1F, 1'b1}, // R9
    '{10'h000, 1'b1, OFF_RAW,   32'h0000_0004, 32'h0000_0000, 32'h0000_1F1F, 1'b0}  // R3
  };

  logic              clk;
  logic              rst_n;
  logic [EVW-1:0]    evt;
  logic              wr;
  logic [ADDR_W-1:0] addr;
  logic [REG_W-1:0]  wdata;
  logic [REG_W-1:0]  rdata;
  logic              irq;

  int checks = 0;
  int errors = 0;

  spi_irq_ctrl #(.NUM_CH(NCH)) dut (
    .clk_i       (clk),
    .rst_n_i     (rst_n),
    .evt_i       (evt),
    .reg_wr_i    (wr),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [REG_W-1:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  // Drive one cycle of stimulus, then leave the port idle on the RAW offset
  task automatic step(input logic [EVW-1:0] e, input logic w,
                      input logic [ADDR_W-1:0] a, input logic [REG_W-1:0] d);
    @(negedge clk);
    evt = e; wr = w; addr = a; wdata = d;
    @(posedge clk);
    #1;
    evt = '0; wr = 1'b0; addr = OFF_RAW; wdata = '0;
    #0.5;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    evt = '0; wr = 1'b0; addr = OFF_RAW; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [REG_W-1:0] v;
    do_reset();

    // R1 reset state
    rd(OFF_RAW, v);   check("R1 raw", v, 32'h0);
    rd(OFF_MASK, v);  check("R1 mask", v, 32'h0);
    rd(OFF_MSTAT, v); check("R1 mstat", v, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);

    // R1 event with zero mask: sets status, no interrupt
    step(10'h020, 1'b0, OFF_RAW, 32'h0);
    rd(OFF_RAW, v); check("R1 raw after event", v, 32'h0000_0100);
    check("R1 irq masked off", {31'h0, irq}, 32'h0);
    // R9 unmapped read returns zero
    rd(5'h14, v); check("R9 unmapped read", v, 32'h0);
    step('0, 1'b1, OFF_RAW, 32'hFF00_1F1F);
    rd(OFF_RAW, v); check("R8 clear", v, 32'h0);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      step(VECS[i].evt, VECS[i].wr, VECS[i].addr, VECS[i].wdata);
      rd(OFF_RAW, v);   check($sformatf("R2/R3 raw vec %0d", i), v, VECS[i].exp_raw);
      rd(OFF_MASK, v);  check($sformatf("R10 mask vec %0d", i), v, VECS[i].exp_mask);
      rd(OFF_MSTAT, v); check($sformatf("R6 mstat vec %0d", i), v, VECS[i].exp_raw & VECS[i].exp_mask);
      check($sformatf("R7 irq vec %0d", i), {31'h0, irq}, {31'h0, VECS[i].exp_irq});
    end

    // R4 event and clear of every bit together
    step('1, 1'b1, OFF_RAW, 32'hFFFF_FFFF);
    rd(OFF_RAW, v); check("R4 all set wins", v, 32'h0000_1F1F);
    // R5 undefined bits stay zero in masked view
    rd(OFF_MSTAT, v); check("R5 mstat", v, 32'h0000_1F1F);

    // R1 reset mid-run clears state
    do_reset();
    rd(OFF_RAW, v);  check("R1 raw after reset", v, 32'h0);
    rd(OFF_MASK, v); check("R1 mask after reset", v, 32'h0);
    check("R1 irq after reset", {31'h0, irq}, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule